// File: doc/BRIEF.md
# Shadow Memory Region Router

This block holds the configuration registers that control shadow memory. It sits behind a pair of I/O ports: an index port that selects a register and a data port that reads or writes the selected register. From the register contents it works out, in combinational logic, where each memory request in the 256 KB window just below 1 MB should go. A read goes to internal shadow DRAM or to the external bus, where the ROM sits. A write goes to internal DRAM or to the external bus, or it is discarded.

The C0000–EFFFF area is split into 16 KB segments, and each segment has its own read enable and write enable. A write-protect bit for each 64 KB block overrides the write routing of every segment in that block. The F0000–FFFFF area is routed as one piece. After reset its reads go to the external ROM, so firmware can copy the ROM into shadow DRAM and then switch reads over to the copy. Accesses below C0000 always go to internal memory. The block does not contain the DRAM, cache control or wait-state logic.

Top module: `shadow_route_ctrl`

## Requirements
- R1: A write to I/O port 0x22 loads the 8-bit index register. A read of port 0x22 returns the current index, and the index is 0x00 after reset.
- R2: Port 0x24 reads and writes the register selected by the index. Indices 0x23 to 0x27 are storage registers that read back the value last written. Any other index reads 0xFF, and a write to it changes none of the five registers.
- R3: After reset, register 0x23 holds 0x40 and registers 0x24 to 0x27 hold 0x00.
- R4: A memory request with an address below 0xC0000 routes reads and writes to internal memory.
- R5: Register 0x26 controls C0000–CFFFF, 0x25 controls D0000–DFFFF and 0x24 controls E0000–EFFFF. The segment number n is address bits 15:14. Bit 4+n is the segment's read enable: 1 sends reads to internal memory and 0 sends them to the external bus.
- R6: In the same registers, bit n is the segment's write enable: 1 sends writes to internal memory and 0 sends them to the external bus.
- R7: Register 0x27 holds the block write protects: bit 4 for C, bit 5 for D and bit 6 for E. While a block's bit is 1, every write to that block is discarded, whatever its write enables say.
- R8: Reads in F0000–FFFFF go to internal memory when bit 6 of register 0x23 is 0 and to the external bus when it is 1.
- R9: Writes in F0000–FFFFF go to internal memory unless bit 7 of register 0x27 is 1, in which case they are discarded.
- R10: During a memory request exactly one of the five routing outputs is high, and none is high without a request. A register write is in force for a request in the cycle after the write edge.
- R11: io_rdata_o is 0x00 unless io_rd_i is high with io_addr_i equal to one of the two ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_wr_i | input | 1 | I/O write strobe, sampled on the clock edge |
| io_rd_i | input | 1 | I/O read strobe |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| mem_req_i | input | 1 | Memory request valid |
| mem_we_i | input | 1 | Request type: 1 write, 0 read |
| mem_addr_i | input | 20 | Memory address |
| rd_int_o | output | 1 | Read goes to internal DRAM |
| rd_ext_o | output | 1 | Read goes to the external bus |
| wr_int_o | output | 1 | Write goes to internal DRAM |
| wr_ext_o | output | 1 | Write goes to the external bus |
| wr_drop_o | output | 1 | Write is discarded |

## Verification
The bench builds the block with its default parameters: ports 0x22 and 0x24, registers 0x23 to 0x27, three 64 KB blocks of four 16 KB segments each, and a 20-bit memory address. With these values one model in the bench can reach all twelve segments, each block's write protect, both settings of the F region and the address just below the shadowed window. The bench programs alternating enable patterns and then inverts them, so every segment is seen routing both internally and externally. It also checks the write-protect override against segments whose write enable is set.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;
  typedef enum logic [1:0] {
    BLK_C = 2'd0,
    BLK_D = 2'd1,
    BLK_E = 2'd2,
    BLK_F = 2'd3
  } blk_e;

  typedef struct packed {
    logic rd_int;
    logic wr_int;
    logic wr_drop;
  } attr_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned DW       = 8,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0024,
  parameter logic [7:0]  REG_BASE = 8'h23,
  parameter int unsigned NUM_REGS = 5,
  parameter logic [7:0]  REG0_RST = 8'h40
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IO_AW-1:0]             io_addr_i,
  input  logic [DW-1:0]                io_wdata_i,
  input  logic                         io_wr_i,
  input  logic                         io_rd_i,
  output logic [DW-1:0]                io_rdata_o,
  output logic [NUM_REGS-1:0][DW-1:0]  cfg_o
);
  logic [DW-1:0] idx_q;
  logic          idx_sel, dat_sel;
  logic [NUM_REGS-1:0] hit;
  logic [DW-1:0] dat_rd;

  assign idx_sel = (io_addr_i == IDX_PORT[IO_AW-1:0]);
  assign dat_sel = (io_addr_i == DAT_PORT[IO_AW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (io_wr_i && idx_sel) idx_q <= io_wdata_i;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [DW-1:0] MY_IDX = DW'(REG_BASE) + DW'(r);
    localparam logic [DW-1:0] RST    = (r == 0) ? DW'(REG0_RST) : '0;
    assign hit[r] = (idx_q == MY_IDX);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           cfg_o[r] <= RST;
      else if (io_wr_i && dat_sel && hit[r]) cfg_o[r] <= io_wdata_i;
    end
  end

  always_comb begin
    dat_rd = '1;  // unimplemented index
    for (int r = 0; r < NUM_REGS; r++)
      if (hit[r]) dat_rd = cfg_o[r];
  end

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i && idx_sel)      io_rdata_o = idx_q;
    else if (io_rd_i && dat_sel) io_rdata_o = dat_rd;
  end
endmodule

// File: rtl/shadow_region_dec.sv
module shadow_region_dec
  import shadow_route_pkg::*;
#(
  parameter int unsigned MEM_AW = 20,
  parameter int unsigned SEG_W  = 2
) (
  input  logic [MEM_AW-1:0] addr_i,
  output logic              upper_o,
  output blk_e              blk_o,
  output logic [SEG_W-1:0]  seg_o
);
  localparam int unsigned TOP_LSB = MEM_AW - 2;
  localparam int unsigned BLK_LSB = MEM_AW - 4;
  localparam int unsigned SEG_LSB = BLK_LSB - SEG_W;

  assign upper_o = (addr_i[MEM_AW-1:TOP_LSB] == 2'b11);
  assign blk_o   = blk_e'(addr_i[TOP_LSB-1:BLK_LSB]);
  assign seg_o   = addr_i[BLK_LSB-1:SEG_LSB];
endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel
  import shadow_route_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned NUM_BLKS = 3,
  parameter int unsigned SEGS     = 4,
  parameter int unsigned SEG_W    = 2,
  parameter int unsigned WP_LSB   = 4,
  parameter int unsigned F_RD_BIT = 6,
  parameter int unsigned F_WP_BIT = 7
) (
  input  logic [NUM_BLKS-1:0][DW-1:0] blk_cfg_i,
  input  logic [DW-1:0]               f_cfg_i,
  input  logic [DW-1:0]               wp_cfg_i,
  input  logic                        upper_i,
  input  blk_e                        blk_i,
  input  logic [SEG_W-1:0]            seg_i,
  output attr_t                       attr_o
);
  attr_t seg_attr [NUM_BLKS];
  attr_t f_attr;

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    logic [SEGS-1:0] rd_en, wr_en;
    logic            prot;
    assign rd_en = blk_cfg_i[b][SEGS +: SEGS];
    assign wr_en = blk_cfg_i[b][0 +: SEGS];
    assign prot  = wp_cfg_i[WP_LSB + b];
    assign seg_attr[b].rd_int  = rd_en[seg_i];
    assign seg_attr[b].wr_drop = prot;
    assign seg_attr[b].wr_int  = wr_en[seg_i] & ~prot;
  end

  // F polarity: set bit means ROM
  assign f_attr.rd_int  = ~f_cfg_i[F_RD_BIT];
  assign f_attr.wr_drop = wp_cfg_i[F_WP_BIT];
  assign f_attr.wr_int  = ~wp_cfg_i[F_WP_BIT];

  always_comb begin
    attr_o = '{rd_int: 1'b1, wr_int: 1'b1, wr_drop: 1'b0};
    if (upper_i) begin
      if (blk_i == BLK_F) attr_o = f_attr;
      else
        for (int b = 0; b < NUM_BLKS; b++)
          if (blk_i == blk_e'(b)) attr_o = seg_attr[b];
    end
  end
endmodule

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
  import shadow_route_pkg::*;
#(
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned MEM_AW   = 20,
  parameter int unsigned NUM_BLKS = 3,
  parameter int unsigned SEGS     = 4,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0024,
  parameter logic [7:0]  REG_BASE = 8'h23,
  parameter logic [7:0]  F_RST    = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [DW-1:0]     io_wdata_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  output logic [DW-1:0]     io_rdata_o,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [MEM_AW-1:0] mem_addr_i,
  output logic              rd_int_o,
  output logic              rd_ext_o,
  output logic              wr_int_o,
  output logic              wr_ext_o,
  output logic              wr_drop_o
);
  localparam int unsigned SEG_W    = $clog2(SEGS);
  // register order: F read, blocks high to low, write protect
  localparam int unsigned NUM_REGS = NUM_BLKS + 2;
  localparam int unsigned WP_REG   = NUM_REGS - 1;

  logic [NUM_REGS-1:0][DW-1:0] cfg;
  logic [NUM_BLKS-1:0][DW-1:0] blk_cfg;
  logic                        upper;
  blk_e                        blk;
  logic [SEG_W-1:0]            seg;
  attr_t                       attr;

  shadow_cfg_regs #(
    .IO_AW(IO_AW), .DW(DW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT),
    .REG_BASE(REG_BASE), .NUM_REGS(NUM_REGS), .REG0_RST(F_RST)
  ) u_regs (
    .clk_i, .rst_ni, .io_addr_i, .io_wdata_i, .io_wr_i, .io_rd_i,
    .io_rdata_o, .cfg_o(cfg)
  );

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_map
    assign blk_cfg[b] = cfg[NUM_BLKS - b];
  end

  shadow_region_dec #(.MEM_AW(MEM_AW), .SEG_W(SEG_W)) u_dec (
    .addr_i(mem_addr_i), .upper_o(upper), .blk_o(blk), .seg_o(seg)
  );

  shadow_route_sel #(
    .DW(DW), .NUM_BLKS(NUM_BLKS), .SEGS(SEGS), .SEG_W(SEG_W)
  ) u_sel (
    .blk_cfg_i(blk_cfg), .f_cfg_i(cfg[0]), .wp_cfg_i(cfg[WP_REG]),
    .upper_i(upper), .blk_i(blk), .seg_i(seg), .attr_o(attr)
  );

  assign rd_int_o  = mem_req_i & ~mem_we_i &  attr.rd_int;
  assign rd_ext_o  = mem_req_i & ~mem_we_i & ~attr.rd_int;
  assign wr_int_o  = mem_req_i &  mem_we_i &  attr.wr_int;
  assign wr_ext_o  = mem_req_i &  mem_we_i & ~attr.wr_int & ~attr.wr_drop;
  assign wr_drop_o = mem_req_i &  mem_we_i &  attr.wr_drop;
endmodule

module shadow_route_ctrl_chk #(
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned MEM_AW = 20,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IO_AW-1:0]  io_addr_i,
  input logic [DW-1:0]     io_wdata_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [DW-1:0]     io_rdata_o,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic [MEM_AW-1:0] mem_addr_i,
  input logic              rd_int_o,
  input logic              rd_ext_o,
  input logic              wr_int_o,
  input logic              wr_ext_o,
  input logic              wr_drop_o
);
  logic [4:0] route;
  logic       low_area;
  assign route    = {rd_int_o, rd_ext_o, wr_int_o, wr_ext_o, wr_drop_o};
  assign low_area = (mem_addr_i[MEM_AW-1 -: 2] != 2'b11);

  assert_one_route_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> $countones(route) == 1);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_i |-> route == 5'b0);
  assert_low_internal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && low_area) |-> (rd_int_o || wr_int_o));
  assert_index_readback_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == IDX_PORT[IO_AW-1:0]) ##1 (io_rd_i && io_addr_i == IDX_PORT[IO_AW-1:0])
    |-> io_rdata_o == $past(io_wdata_i));
  assert_rdata_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rd_i || (io_addr_i != IDX_PORT[IO_AW-1:0] && io_addr_i != DAT_PORT[IO_AW-1:0]))
    |-> io_rdata_o == '0);
  assert_drop_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> !low_area);
endmodule

bind shadow_route_ctrl shadow_route_ctrl_chk u_chk (.*);

// File: tb/shadow_route_ctrl_test.sv
`timescale 1ns/1ps
module shadow_route_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        mem_req = 1'b0, mem_we = 1'b0;
  logic [19:0] mem_addr = '0;
  logic        rd_int, rd_ext, wr_int, wr_ext, wr_drop;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // {rd_int, rd_ext, wr_int, wr_ext, wr_drop}
  localparam logic [4:0] RI = 5'b10000, RE = 5'b01000, WI = 5'b00100,
                         WE = 5'b00010, WD = 5'b00001;

  logic [4:0]  exp_q [$];
  string       tag_q [$];
  logic [19:0] adr_q [$];

  logic [7:0] m_f = 8'h40, m_e = 8'h00, m_d = 8'h00, m_c = 8'h00, m_wp = 8'h00;

  always #2 clk = ~clk;

  shadow_route_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_rdata_o(io_rdata),
    .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_addr_i(mem_addr),
    .rd_int_o(rd_int), .rd_ext_o(rd_ext), .wr_int_o(wr_int),
    .wr_ext_o(wr_ext), .wr_drop_o(wr_drop)
  );

  function automatic logic [4:0] model(logic [19:0] a, logic w);
    logic [1:0] b, s;
    logic [7:0] r;
    if (a[19:18] != 2'b11) return w ? WI : RI;
    b = a[17:16]; s = a[15:14];
    if (b == 2'd3) begin
      if (!w) return m_f[6] ? RE : RI;
      return m_wp[7] ? WD : WI;
    end
    r = (b == 2'd0) ? m_c : (b == 2'd1) ? m_d : m_e;
    if (!w) return r[4 + s] ? RI : RE;
    if (m_wp[4 + b]) return WD;
    return r[s] ? WI : WE;
  endfunction

  function automatic string req_tag(logic [19:0] a, logic w);
    if (a[19:18] != 2'b11) return "R4";
    if (a[17:16] == 2'b11) return w ? "R9" : "R8";
    if (!w) return "R5";
    return m_wp[4 + a[17:16]] ? "R7" : "R6";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic reg_write(logic [7:0] idx, logic [7:0] d);
    io_write(16'h22, idx);
    io_write(16'h24, d);
    case (idx)
      8'h23: m_f = d;
      8'h24: m_e = d;
      8'h25: m_d = d;
      8'h26: m_c = d;
      8'h27: m_wp = d;
      default: ;
    endcase
  endtask

  task automatic io_read(logic [15:0] a, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    check(tag, io_rdata, exp);
    #1 io_rd = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] idx, logic [7:0] exp, string tag);
    io_write(16'h22, idx);
    io_read(16'h24, exp, tag);
  endtask

  // driver: push expected route, hold request for one cycle
  task automatic mem_access(logic [19:0] a, logic w);
    @(posedge clk); #1;
    mem_addr = a; mem_we = w; mem_req = 1'b1;
    exp_q.push_back(model(a, w));
    tag_q.push_back(req_tag(a, w));
    adr_q.push_back(a);
    @(posedge clk); #1;
    mem_req = 1'b0;
  endtask

  task automatic sweep_upper();
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 4; s++) begin
        mem_access(20'hC0000 + 20'(b) * 20'h10000 + 20'(s) * 20'h4000 + 20'h123, 1'b0);
        mem_access(20'hC0000 + 20'(b) * 20'h10000 + 20'(s) * 20'h4000 + 20'h3FF0, 1'b1);
      end
  endtask

  // monitor: compare routing while a request is held
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (exp_q.size() == 0) check("R10 unexpected request", 1, 0);
      else begin
        logic [4:0]  e;
        string       t;
        logic [19:0] a;
        e = exp_q.pop_front(); t = tag_q.pop_front(); a = adr_q.pop_front();
        check($sformatf("%s addr=%05h", t, a), {rd_int, rd_ext, wr_int, wr_ext, wr_drop}, e);
      end
    end else if (rst_n) begin
      check("R10 idle", {rd_int, rd_ext, wr_int, wr_ext, wr_drop}, 0);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R3 / R1 reset state
    io_read(16'h22, 8'h00, "R1 reset index");
    reg_read(8'h23, 8'h40, "R3 reg23");
    reg_read(8'h24, 8'h00, "R3 reg24");
    reg_read(8'h25, 8'h00, "R3 reg25");
    reg_read(8'h26, 8'h00, "R3 reg26");
    reg_read(8'h27, 8'h00, "R3 reg27");
    sweep_upper();
    mem_access(20'h00000, 1'b0);
    mem_access(20'hBFFFF, 1'b0);
    mem_access(20'hBFFFF, 1'b1);

    // R1 index readback
    io_write(16'h22, 8'h5A);
    io_read(16'h22, 8'h5A, "R1 index");

    // R2 storage and unimplemented index
    reg_write(8'h24, 8'hA5);
    reg_read(8'h24, 8'hA5, "R2 reg24");
    reg_write(8'h20, 8'h3C);
    reg_read(8'h20, 8'hFF, "R2 unimpl 20");
    reg_read(8'h28, 8'hFF, "R2 unimpl 28");
    reg_read(8'h23, 8'h40, "R2 reg23 untouched");
    reg_read(8'h24, 8'hA5, "R2 reg24 untouched");
    reg_read(8'h27, 8'h00, "R2 reg27 untouched");

    // R11 read data idle
    io_read(16'h23, 8'h00, "R11 other port");
    @(negedge clk); io_addr = 16'h22;
    @(negedge clk); check("R11 no strobe", io_rdata, 8'h00);

    // R5 R6 alternating patterns, then inverted
    reg_write(8'h24, 8'h5A);
    reg_write(8'h25, 8'hC3);
    reg_write(8'h26, 8'h96);
    sweep_upper();
    reg_write(8'h24, 8'hA5);
    reg_write(8'h25, 8'h3C);
    reg_write(8'h26, 8'h69);
    sweep_upper();

    // R8 F read internal, R10 takes effect on next access
    reg_write(8'h23, 8'h00);
    mem_access(20'hF0000, 1'b0);
    mem_access(20'hFFFFF, 1'b0);

    // R7 write protect per block with write enables set
    reg_write(8'h24, 8'hFF);
    reg_write(8'h25, 8'hFF);
    reg_write(8'h26, 8'hFF);
    reg_write(8'h27, 8'h10);
    sweep_upper();
    reg_write(8'h27, 8'h20);
    sweep_upper();
    reg_write(8'h27, 8'h40);
    sweep_upper();
    // R9 F write protect
    reg_write(8'h27, 8'h80);
    sweep_upper();
    reg_write(8'h27, 8'hF0);
    reg_write(8'h23, 8'h40);
    sweep_upper();
    mem_access(20'h9ABCD, 1'b1);

    @(posedge clk);
    @(posedge clk);
    check("R10 all requests seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule